// File: doc/BRIEF.md
# Auto-Increment Buffer Access Port

This block is a small register window that lets a simple host bus reach a large internal buffer memory through a single data register. The host sees 32 word-wide register slots. Four of them are decoded: a buffer selector, an offset pointer, the data access register and a status register. The remaining slots read as zero and ignore writes. Every host transaction is a single-word access; there are no bursts.

To stream a buffer, the host writes the selector and then the offset. Writing the offset makes the port busy for a fixed number of cycles while it prefetches the first word. After that, each read or write of the data register moves a hidden pointer forward by one word, and the next word is prefetched on the same edge. Data words are 16 bits wide, and the upper half of every 32-bit read is zero.

When the pointer walks off the end of the selected buffer, the error flag is raised. While it is raised, data reads return zero, data writes are dropped and the pointer holds. A new in-range offset clears the flag. An access to the data register while the port is busy is held off with `hostReady` low.

Top module: `buf_access_port`

## Requirements
- R1: A synchronous active-low reset clears the selector, the pointer and the busy and error status, so the selector, offset and status registers all read 0.
- R2: The 5-bit register index decodes as follows: 0 is the selector, 1 is the offset/pointer, 2 is the data access register and 3 is the status register (bit 0 busy, bit 1 error). Every other index reads 0, and a write to one of them changes no register.
- R3: A write to the offset register holds busy high for PREFETCH_CYCLES cycles. After that, the data register presents the word at (selector, offset).
- R4: An accepted read of the data register returns the current word in bits 15:0. The pointer then moves forward by one, and the following word is ready for the next access with no wait.
- R5: An accepted write of the data register stores bits 15:0 at the pointer and moves the pointer forward by one. Bits 31:16 are discarded.
- R6: Bits 31:16 of every host read are zero.
- R7: While busy is high, an access to the data register sees `hostReady` low and takes no effect until busy clears. Accesses to other registers stay ready.
- R8: When the pointer moves forward from the last word of a buffer, the error bit sets and the offset register reads BUF_WORDS.
- R9: While the error bit is set, data reads return 0, data writes store nothing and the pointer holds. An offset write of BUF_WORDS or more sets the error bit at once (the offset then reads BUF_WORDS). An in-range offset write clears it.
- R10: The selector picks which buffer the pointer addresses, so the same offset in two buffers holds independent words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hostReq | input | 1 | Host transaction request, held until accepted |
| hostWe | input | 1 | 1 = write, 0 = read |
| hostAddr | input | 5 | Register index within the window |
| hostWdata | input | 32 | Write data |
| hostRdata | output | 32 | Read data, valid in the request cycle |
| hostReady | output | 1 | Transaction accepted at the next clock edge when high with hostReq |

## Verification
The bench builds the port with 4 buffers of 8 words and a 3-cycle prefetch. Eight words are enough to fill a buffer completely and walk past its end, which exercises the error entry, the frozen pointer and recovery without long loops. A prefetch of more than one cycle makes the ready hold-off measurable both right after an offset write and part-way through the busy window.

// File: rtl/bap_pkg.sv
package bap_pkg;
  localparam int HOST_W    = 32;
  localparam int WORD_W    = 16;
  localparam int REG_IDX_W = 5;

  localparam logic [REG_IDX_W-1:0] REG_SEL  = 5'd0;
  localparam logic [REG_IDX_W-1:0] REG_OFF  = 5'd1;
  localparam logic [REG_IDX_W-1:0] REG_DATA = 5'd2;
  localparam logic [REG_IDX_W-1:0] REG_STAT = 5'd3;

  typedef struct packed {
    logic selWr;
    logic offWr;
    logic accRd;
    logic accWr;
    logic prefetch;
  } bapStrobe_t;
endpackage

// File: rtl/bap_ctrl.sv
module bap_ctrl
  import bap_pkg::*;
#(
  parameter int PREFETCH_CYCLES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 hostReq,
  input  logic                 hostWe,
  input  logic [REG_IDX_W-1:0] hostAddr,
  output logic                 hostReady,
  output logic                 busy,
  output bapStrobe_t           strobe
);
  localparam int CNT_W = $clog2(PREFETCH_CYCLES + 1);

  logic [CNT_W-1:0] busyCnt;
  logic             accept;
  logic             offWrite;

  assign busy      = (busyCnt != '0);
  assign hostReady = !(busy && hostAddr == REG_DATA);
  assign accept    = hostReq && hostReady;
  assign offWrite  = accept && hostWe && hostAddr == REG_OFF;

  always_comb begin
    strobe          = '0;
    strobe.selWr    = accept && hostWe && hostAddr == REG_SEL;
    strobe.offWr    = offWrite;
    strobe.accRd    = accept && !hostWe && hostAddr == REG_DATA;
    strobe.accWr    = accept && hostWe && hostAddr == REG_DATA;
    strobe.prefetch = (busyCnt == CNT_W'(1)) && !offWrite;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busyCnt <= '0;
    end else if (offWrite) begin
      busyCnt <= CNT_W'(PREFETCH_CYCLES);
    end else if (busy) begin
      busyCnt <= busyCnt - 1'b1;
    end
  end

  // An offset write starts the prefetch window (R3)
  assert_busy_on_offset_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hostReq && hostReady && hostWe && hostAddr == REG_OFF) |=> busy);

  // The window shrinks by one per cycle unless restarted (R3)
  assert_busy_countdown_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !offWrite) |=> (busyCnt == CNT_W'($past(busyCnt) - 1'b1)));

  // No data access is taken while the prefetch is in flight (R7)
  assert_hold_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && hostReq && hostAddr == REG_DATA) |-> !(strobe.accRd || strobe.accWr));
endmodule

// File: rtl/bap_dp.sv
module bap_dp
  import bap_pkg::*;
#(
  parameter int NUM_BUFS  = 4,
  parameter int BUF_WORDS = 256
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  bapStrobe_t           strobe,
  input  logic                 busy,
  input  logic [REG_IDX_W-1:0] hostAddr,
  input  logic [HOST_W-1:0]    hostWdata,
  output logic [HOST_W-1:0]    hostRdata
);
  localparam int SEL_W     = $clog2(NUM_BUFS);
  localparam int OFF_W     = $clog2(BUF_WORDS);
  localparam int PTR_W     = OFF_W + 1;
  localparam int MEM_DEPTH = NUM_BUFS * BUF_WORDS;
  localparam int MEM_AW    = SEL_W + OFF_W;
  localparam logic [PTR_W-1:0] PTR_END = PTR_W'(BUF_WORDS);

  logic [WORD_W-1:0] mem [MEM_DEPTH];
  logic [SEL_W-1:0]  sel;
  logic [PTR_W-1:0]  ptr;
  logic [PTR_W-1:0]  nextPtr;
  logic [WORD_W-1:0] dataReg;
  logic [MEM_AW-1:0] curIdx;
  logic [MEM_AW-1:0] nextIdx;
  logic              errFlag;
  logic              nextAtEnd;
  logic              offInRange;
  logic              unusedHi;

  assign errFlag    = (ptr == PTR_END);
  assign nextPtr    = ptr + 1'b1;
  assign nextAtEnd  = (nextPtr == PTR_END);
  assign curIdx     = {sel, ptr[OFF_W-1:0]};
  assign nextIdx    = {sel, nextPtr[OFF_W-1:0]};
  assign offInRange = (hostWdata[WORD_W-1:0] < WORD_W'(BUF_WORDS));
  assign unusedHi   = ^hostWdata[HOST_W-1:WORD_W];

  always_ff @(posedge clk) begin
    if (strobe.accWr && !errFlag) begin
      mem[curIdx] <= hostWdata[WORD_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel     <= '0;
      ptr     <= '0;
      dataReg <= '0;
    end else begin
      if (strobe.selWr) begin
        sel <= hostWdata[SEL_W-1:0];
      end
      if (strobe.offWr) begin
        ptr     <= offInRange ? PTR_W'(hostWdata[OFF_W-1:0]) : PTR_END;
        dataReg <= '0;
      end else if (strobe.prefetch) begin
        dataReg <= errFlag ? '0 : mem[curIdx];
      end else if ((strobe.accRd || strobe.accWr) && !errFlag) begin
        ptr     <= nextPtr;
        dataReg <= nextAtEnd ? '0 : mem[nextIdx];
      end
    end
  end

  always_comb begin
    unique case (hostAddr)
      REG_SEL:  hostRdata = HOST_W'(sel);
      REG_OFF:  hostRdata = HOST_W'(ptr);
      REG_DATA: hostRdata = HOST_W'(errFlag ? '0 : dataReg);
      REG_STAT: hostRdata = HOST_W'({errFlag, busy});
      default:  hostRdata = '0;
    endcase
  end

  // Each taken access moves the pointer by exactly one word (R4, R5)
  assert_ptr_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((strobe.accRd || strobe.accWr) && !errFlag) |=> (ptr == $past(ptr) + 1'b1));

  // Once past the end, only an offset write moves the pointer (R9)
  assert_err_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (errFlag && !strobe.offWr) |=> (errFlag && $stable(ptr)));

  // The pointer never goes beyond one past the last word (R8)
  assert_ptr_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= PTR_END);
endmodule

// File: rtl/buf_access_port.sv
module buf_access_port
  import bap_pkg::*;
#(
  parameter int NUM_BUFS        = 4,
  parameter int BUF_WORDS       = 256,
  parameter int PREFETCH_CYCLES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hostReq,
  input  logic        hostWe,
  input  logic [4:0]  hostAddr,
  input  logic [31:0] hostWdata,
  output logic [31:0] hostRdata,
  output logic        hostReady
);
  bapStrobe_t strobe;
  logic       busy;

  bap_ctrl #(
    .PREFETCH_CYCLES(PREFETCH_CYCLES)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .hostReq  (hostReq),
    .hostWe   (hostWe),
    .hostAddr (hostAddr),
    .hostReady(hostReady),
    .busy     (busy),
    .strobe   (strobe)
  );

  bap_dp #(
    .NUM_BUFS (NUM_BUFS),
    .BUF_WORDS(BUF_WORDS)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .busy     (busy),
    .hostAddr (hostAddr),
    .hostWdata(hostWdata),
    .hostRdata(hostRdata)
  );
endmodule

// File: tb/buf_access_port_bench.sv
`timescale 1ns/1ps
module buf_access_port_bench;
  localparam int NB = 4;
  localparam int BW = 8;
  localparam int PF = 3;
  localparam logic [4:0] A_SEL = 5'd0, A_OFF = 5'd1, A_DATA = 5'd2, A_STAT = 5'd3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hostReq = 1'b0;
  logic        hostWe = 1'b0;
  logic [4:0]  hostAddr = '0;
  logic [31:0] hostWdata = '0;
  logic [31:0] hostRdata;
  logic        hostReady;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  buf_access_port #(.NUM_BUFS(NB), .BUF_WORDS(BW), .PREFETCH_CYCLES(PF)) u_buf_access_port (
    .clk(clk), .rst_n(rst_n), .hostReq(hostReq), .hostWe(hostWe), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .hostReady(hostReady)
  );

  always #4 clk = ~clk;

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 50000 && !done) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected<50000", cycles);
        summary();
        $finish;
      end
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Called at a negedge; returns at a negedge.
  task automatic xfer(input logic we, input logic [4:0] addr, input logic [31:0] wd,
                      output logic [31:0] rd, output int waited);
    hostReq = 1'b1; hostWe = we; hostAddr = addr; hostWdata = wd;
    waited = 0;
    #1;
    while (!hostReady) begin
      @(negedge clk); #1;
      waited++;
    end
    rd = hostRdata;
    @(negedge clk);
    hostReq = 1'b0; hostWe = 1'b0;
  endtask

  task automatic wr(input logic [4:0] addr, input logic [31:0] wd);
    logic [31:0] rd; int w;
    xfer(1'b1, addr, wd, rd, w);
  endtask

  task automatic rdChk(string tag, input logic [4:0] addr, input logic [31:0] exp);
    logic [31:0] rd; int w;
    xfer(1'b0, addr, 32'h0, rd, w);
    check(tag, rd, exp);
  endtask

  task automatic testReset();
    rdChk("R1 selector after reset", A_SEL, 32'd0);
    rdChk("R1 offset after reset", A_OFF, 32'd0);
    rdChk("R1 status after reset", A_STAT, 32'd0);
  endtask

  task automatic testDecode();
    wr(A_SEL, 32'd2);
    wr(5'd9, 32'hFFFF_FFFF);
    rdChk("R2 unused index reads zero", 5'd9, 32'd0);
    rdChk("R2 selector kept after stray write", A_SEL, 32'd2);
    rdChk("R2 offset kept after stray write", A_OFF, 32'd0);
    rdChk("R2 top index reads zero", 5'd31, 32'd0);
  endtask

  task automatic testFill();
    wr(A_SEL, 32'd1);
    wr(A_OFF, 32'd0);
    for (int i = 0; i < BW; i++) wr(A_DATA, 32'hFFFF_A000 + i);
    rdChk("R8 error after last word", A_STAT, 32'd2);
    rdChk("R8 offset at end", A_OFF, BW);
  endtask

  task automatic testErrIgnore();
    rdChk("R9 data reads zero in error", A_DATA, 32'd0);
    wr(A_DATA, 32'h0000_1234);
    rdChk("R9 pointer holds in error", A_OFF, BW);
    rdChk("R9 error stays set", A_STAT, 32'd2);
  endtask

  task automatic testReadBack();
    logic [31:0] rd; int w;
    wr(A_OFF, 32'd0);
    xfer(1'b0, A_DATA, 32'h0, rd, w);
    check("R7 wait after offset write", w, PF);
    check("R3 first word after prefetch", rd, 32'h0000_A000);
    for (int i = 1; i < BW; i++) begin
      xfer(1'b0, A_DATA, 32'h0, rd, w);
      check("R4 streaming read no wait", w, 0);
      check("R4 R5 R6 streamed word", rd, 32'h0000_A000 + i);
    end
    rdChk("R8 error after reading past end", A_STAT, 32'd2);
  endtask

  task automatic testBusyStatus();
    logic [31:0] rd; int w;
    wr(A_OFF, 32'd5);
    xfer(1'b0, A_STAT, 32'h0, rd, w);
    check("R7 status ready while busy", w, 0);
    check("R3 busy bit after offset write", rd, 32'd1);
    xfer(1'b0, A_DATA, 32'h0, rd, w);
    check("R7 remaining wait", w, PF - 1);
    check("R3 word at offset 5", rd, 32'h0000_A005);
  endtask

  task automatic testSelect();
    wr(A_SEL, 32'd2);
    wr(A_OFF, 32'd0);
    wr(A_DATA, 32'h0000_5555);
    wr(A_SEL, 32'd1);
    wr(A_OFF, 32'd0);
    rdChk("R10 buffer 1 word 0", A_DATA, 32'h0000_A000);
    wr(A_SEL, 32'd2);
    wr(A_OFF, 32'd0);
    rdChk("R10 buffer 2 word 0", A_DATA, 32'h0000_5555);
  endtask

  task automatic testBadOffset();
    wr(A_SEL, 32'd1);
    wr(A_OFF, 32'd20);
    rdChk("R9 bad offset sets error at once", A_STAT, 32'd3);
    rdChk("R9 bad offset reads end", A_OFF, BW);
    wr(A_OFF, 32'd3);
    rdChk("R9 good offset recovers", A_DATA, 32'h0000_A003);
    rdChk("R9 error cleared", A_STAT, 32'd0);
  endtask

  task automatic testMidReset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rdChk("R1 selector after second reset", A_SEL, 32'd0);
    rdChk("R1 offset after second reset", A_OFF, 32'd0);
    rdChk("R1 status after second reset", A_STAT, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    testDecode();
    testFill();
    testErrIgnore();
    testReadBack();
    testBusyStatus();
    testSelect();
    testBadOffset();
    testMidReset();
    done = 1'b1;
    summary();
    $finish;
  end
endmodule